// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers interrupt requests for a processor core and hands the core one winner at a time as a program-memory vector address. There are thirteen sources. Four are fatal or software events at the high level: illegal opcode, software trap, hardware-stack overflow and debug trap. Nine are maskable sources at the low level: two external active-low pins and seven peripheral channels. A separate reset request pre-empts everything. A 16-bit configuration register holds the enable bit of each channel and the enable and trigger-mode bits of each pin.

The core sees `irq_valid` with `irq_vector`. Both stay fixed until the core pulses `irq_ack`. Every vector entry is two words long. Vectors start at word 0x06 and step by two in priority order, so they stay inside the first 64 words. When the core accepts a software trap, the block pulses `mask_raise` so that the core can raise its mask above zero. The core feeds its current mask back on `core_mask`. Any nonzero mask keeps low-level sources out of arbitration. High-level sources are never masked.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After a write, `cfg_rdata` returns only the writable bits: bits 15..9 enable channels 0..6 (bit 15 is channel 0), bit 1 enables pin A, bit 2 is pin A's mode, bit 4 enables pin B and bit 5 is pin B's mode. Every other bit reads 0, so writing 0xFFFF reads back 0xFE36.
- R2: A channel whose enable bit is 0 never produces a request. It produces one once it is enabled while its input is still high.
- R3: High-level sources win among themselves in the order illegal opcode (0x06), software trap (0x08), stack overflow (0x0A), debug trap (0x0C). Each one-cycle event is held pending until it is acknowledged.
- R4: Low-level sources win among themselves in the order pin A (0x0E), pin B (0x10), then channel k at 0x12+2k.
- R5: Any pending high-level source is presented before any low-level source.
- R6: While `core_mask` is nonzero, no low-level source is presented. High-level sources are still presented.
- R7: A pin in edge mode (mode bit 1) latches a falling edge and is served exactly once, and its pending state clears on acknowledge.
- R8: A pin in level mode (mode bit 0) is presented again after every acknowledge for as long as it is held low.
- R9: A disabled pin is ignored in either mode. An edge seen while the pin is disabled leaves no pending state, so enabling the pin later gives no request.
- R10: Once presented, `irq_valid` and `irq_vector` stay unchanged until `irq_ack`, even when a higher-priority source arrives.
- R11: `mask_raise` pulses for one cycle right after the software-trap vector is acknowledged, and after no other acknowledge.
- R12: `rst_req` drops any presented request, clears all pending events and drives `reset_out` high in the following cycle. Sources that are held as levels come back after `rst_req` is released.
- R13: After `rst`, `irq_valid`, `reset_out`, `mask_raise` and `cfg_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration readback |
| rst_req | input | 1 | Reset request, above all interrupts |
| pin_n | input | 2 | External active-low pins (bit 0 = A), already synchronized |
| chan_req | input | 7 | Peripheral channel request levels |
| stk_ovf | input | 1 | Hardware-stack overflow event |
| dbg_trap | input | 1 | Debug trap event |
| swi_exec | input | 1 | Software trap event |
| ill_op | input | 1 | Illegal opcode event |
| core_mask | input | 2 | Core interrupt mask level |
| irq_valid | output | 1 | Interrupt presented to the core |
| irq_vector | output | 7 | Vector word address of the presented source |
| irq_ack | input | 1 | Core acknowledge pulse |
| mask_raise | output | 1 | Pulse after a software trap is accepted |
| reset_out | output | 1 | Reset request forwarded to the core |

## Verification
The main function is driven with several request patterns. The first fires all four high-level events at once along with two channels, which shows the intra-level order, the level precedence and the software-trap pulse. The second drops both pins at once with a channel, which separates the pin order from the channel order and shows that each edge is served only once. Masked channels mixed with an unmasked debug trap show that the mask applies only to the low level. A pin held low in level mode shows repeated service, while disabled pins and channels show both the ignore rule and the absence of a stale pending state. A late high-priority event during an unacknowledged request, and a reset request that arrives with events pending, show that the presented vector is held and that the reset request overrides and flushes it.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int CFG_W    = 16;
  localparam int NUM_CH   = 7;
  localparam int NUM_PIN  = 2;
  localparam int NUM_HI   = 4;
  localparam int NUM_SRC  = NUM_HI + NUM_PIN + NUM_CH;
  localparam int SRC_W    = $clog2(NUM_SRC);

  // source index = priority rank, 0 is highest
  localparam int SRC_ILL  = 0;
  localparam int SRC_SWI  = 1;
  localparam int SRC_STK  = 2;
  localparam int SRC_DBG  = 3;
  localparam int SRC_PA   = 4;
  localparam int SRC_PB   = 5;
  localparam int SRC_CH0  = 6;

  // configuration bit positions
  localparam int CH_EN_TOP = 15;
  localparam int PA_EN     = 1;
  localparam int PA_MODE   = 2;
  localparam int PB_EN     = 4;
  localparam int PB_MODE   = 5;
  localparam logic [CFG_W-1:0] CFG_WMASK = 16'hFE36;
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= wdata & WMASK;
  end
endmodule

// File: rtl/irq_pin_front.sv
module irq_pin_front (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic pin_n,
  input  logic en,
  input  logic edge_mode,
  input  logic ack_clr,
  output logic req
);
  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall = prev_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (flush || !en || !edge_mode) pend_q <= 1'b0;
      else                            pend_q <= (pend_q & ~ack_clr) | fall;
    end
  end

  assign req = en & (edge_mode ? pend_q : ~pin_n);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N  = 13,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int VEC_W    = 7,
  parameter int VEC_BASE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              rst_req,
  input  logic [1:0]        pin_n,
  input  logic [6:0]        chan_req,
  input  logic              stk_ovf,
  input  logic              dbg_trap,
  input  logic              swi_exec,
  input  logic              ill_op,
  input  logic [1:0]        core_mask,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  input  logic              irq_ack,
  output logic              mask_raise,
  output logic              reset_out
);
  localparam logic [VEC_W-1:0] SWI_VEC = VEC_W'(VEC_BASE + 2 * SRC_SWI);
  localparam logic [VEC_W-1:0] LO_VEC  = VEC_W'(VEC_BASE + 2 * SRC_PA);

  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_CH-1:0]  ch_en;
  logic [NUM_PIN-1:0] pin_en, pin_mode, pin_req;
  logic [NUM_HI-1:0]  hi_pend_q, hi_evt;
  logic [NUM_SRC-1:0] clr_oh, src_req;
  logic [NUM_CH+NUM_PIN-1:0] lo_req;
  logic               busy_q, ack_fire, win_any;
  logic [SRC_W-1:0]   cur_idx_q, win_idx;
  logic [VEC_W-1:0]   vec_q;
  logic               raise_q, rst_out_q;

  irq_cfg_reg #(.W(CFG_W), .WMASK(CFG_WMASK)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );
  assign cfg_rdata = cfg_q;

  genvar k;
  generate
    for (k = 0; k < NUM_CH; k++) begin : g_chen
      assign ch_en[k] = cfg_q[CH_EN_TOP-k];
    end
  endgenerate

  assign pin_en   = {cfg_q[PB_EN],   cfg_q[PA_EN]};
  assign pin_mode = {cfg_q[PB_MODE], cfg_q[PA_MODE]};

  assign ack_fire = busy_q & irq_ack & ~rst_req;
  assign clr_oh   = ack_fire ? (NUM_SRC'(1) << cur_idx_q) : '0;

  // high-level events: latched until acknowledged, flushed by reset request
  assign hi_evt = {dbg_trap, stk_ovf, swi_exec, ill_op};
  always_ff @(posedge clk) begin
    if (rst || rst_req) hi_pend_q <= '0;
    else                hi_pend_q <= (hi_pend_q & ~clr_oh[NUM_HI-1:0]) | hi_evt;
  end

  generate
    for (k = 0; k < NUM_PIN; k++) begin : g_pin
      irq_pin_front u_pin (
        .clk(clk), .rst(rst), .flush(rst_req), .pin_n(pin_n[k]),
        .en(pin_en[k]), .edge_mode(pin_mode[k]),
        .ack_clr(clr_oh[SRC_PA+k]), .req(pin_req[k])
      );
    end
  endgenerate

  assign lo_req  = {chan_req & ch_en, pin_req} & {(NUM_CH+NUM_PIN){core_mask == 2'd0}};
  assign src_req = {lo_req, hi_pend_q};

  irq_arbiter #(.N(NUM_SRC), .IW(SRC_W)) u_arb (
    .req(src_req), .any(win_any), .idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      cur_idx_q <= '0;
      vec_q     <= '0;
      raise_q   <= 1'b0;
      rst_out_q <= 1'b0;
    end else if (rst_req) begin
      busy_q    <= 1'b0;
      raise_q   <= 1'b0;
      rst_out_q <= 1'b1;
    end else begin
      rst_out_q <= 1'b0;
      raise_q   <= ack_fire && (cur_idx_q == SRC_W'(SRC_SWI));
      if (ack_fire) begin
        busy_q <= 1'b0;
      end else if (!busy_q && win_any) begin
        busy_q    <= 1'b1;
        cur_idx_q <= win_idx;
        vec_q     <= VEC_W'(VEC_BASE + 2 * int'(win_idx));
      end
    end
  end

  assign irq_valid  = busy_q;
  assign irq_vector = vec_q;
  assign mask_raise = raise_q;
  assign reset_out  = rst_out_q;

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && !irq_ack && !rst_req) |=> (irq_valid && $stable(irq_vector))); // R10
  AST_MASK_GATES_LO: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_valid) && $past(core_mask) != 2'd0) |-> (irq_vector < LO_VEC)); // R6
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> (!irq_valid && reset_out)); // R12
  AST_SWI_RAISE: assert property (@(posedge clk) disable iff (rst)
    mask_raise |-> $past(irq_valid && irq_ack && irq_vector == SWI_VEC)); // R11
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic rst_req = 1'b0;
  logic [1:0] pin_n;
  logic [6:0] chan_req;
  logic stk_ovf = 1'b0, dbg_trap = 1'b0, swi_exec = 1'b0, ill_op = 1'b0;
  logic [1:0] core_mask = 2'd0;
  logic irq_valid, mask_raise, reset_out;
  logic [6:0] irq_vector;
  logic irq_ack = 1'b0;

  int checks = 0, failures = 0;
  logic [6:0] exp_q[$];
  bit auto_ack = 1'b0;
  int chan_set[7] = '{default: 0};
  int chan_clr[7] = '{default: 0};
  int pa_need = 0, pa_served = 0;
  logic pa_edge_n = 1'b1, pb_edge_n = 1'b1;
  logic [6:0] last_v = '0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 7; i++) chan_req[i] = (chan_set[i] != chan_clr[i]);
  end
  assign pin_n = {pb_edge_n, pa_edge_n & !(pa_served < pa_need)};

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rst_req(rst_req), .pin_n(pin_n), .chan_req(chan_req), .stk_ovf(stk_ovf),
    .dbg_trap(dbg_trap), .swi_exec(swi_exec), .ill_op(ill_op), .core_mask(core_mask),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_ack(irq_ack),
    .mask_raise(mask_raise), .reset_out(reset_out)
  );

  function automatic logic [6:0] chv(int k);
    return 7'(8'h12 + 2 * k);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected vectors, acknowledges, releases level sources
  always @(negedge clk) begin
    if (!rst) begin
      if (irq_ack) begin
        check(mask_raise == (last_v == 7'h08), "R11 mask_raise", mask_raise, last_v == 7'h08);
        irq_ack = 1'b0;
      end else if (auto_ack && irq_valid) begin
        logic [6:0] v;
        v = irq_vector;
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 R6 R7 R9 unexpected vector", v, 0);
        end else begin
          logic [6:0] e;
          e = exp_q.pop_front();
          check(v == e, "R3 R4 R5 vector order", v, e);
        end
        if (v >= 7'h12 && v <= 7'h1E) chan_clr[(v - 7'h12) / 2] = chan_set[(v - 7'h12) / 2];
        if (v == 7'h0E) pa_served++;
        last_v = v;
        irq_ack = 1'b1;
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 200) begin step(); t++; end
    check(exp_q.size() == 0, "R3 R4 drain", exp_q.size(), 0);
    step(10);
  endtask

  task automatic wr(logic [15:0] d);
    cfg_we = 1'b1; cfg_wdata = d; step(); cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    // R13 reset state
    check(!irq_valid && !reset_out && !mask_raise, "R13 outputs", {irq_valid, reset_out, mask_raise}, 0);
    check(cfg_rdata == 16'h0, "R13 cfg", cfg_rdata, 0);
    // R1 readback mask
    wr(16'hFFFF);
    check(cfg_rdata == 16'hFE36, "R1 readback", cfg_rdata, 16'hFE36);
    wr(16'h01C9);
    check(cfg_rdata == 16'h0000, "R1 reserved bits", cfg_rdata, 0);
    wr(16'hFE36);
    auto_ack = 1'b1;

    // R3 R5: all high-level events plus two channels
    exp_q = '{7'h06, 7'h08, 7'h0A, 7'h0C, chv(0), chv(6)};
    ill_op = 1; swi_exec = 1; stk_ovf = 1; dbg_trap = 1;
    step();
    ill_op = 0; swi_exec = 0; stk_ovf = 0; dbg_trap = 0;
    chan_set[0]++; chan_set[6]++;
    drain();

    // R4 R7: both pins fall on edges, one channel a cycle later
    exp_q = '{7'h0E, 7'h10, chv(3)};
    pa_edge_n = 0; pb_edge_n = 0;
    step();
    chan_set[3]++;
    step();
    pa_edge_n = 1; pb_edge_n = 1;
    drain();

    // R6: mask blocks channel, debug trap still served
    core_mask = 2'd1;
    exp_q = '{7'h0C};
    chan_set[2]++;
    dbg_trap = 1; step(); dbg_trap = 0;
    drain();
    check(!irq_valid, "R6 masked channel", irq_valid, 0);
    exp_q = '{chv(2)};
    core_mask = 2'd0;
    drain();

    // R8: pin A level mode, held low for two services
    wr(16'hFE32);
    exp_q = '{7'h0E, 7'h0E};
    pa_need = pa_served + 2;
    drain();
    check(pin_n[0] == 1'b1 && !irq_valid, "R8 release", pin_n[0], 1);

    // R9: pin B disabled, edge dropped, no stale request on enable
    wr(16'hFE22);
    pb_edge_n = 0; step(2); pb_edge_n = 1; step(5);
    check(!irq_valid, "R9 disabled pin", irq_valid, 0);
    wr(16'hFE32);
    step(10);
    check(!irq_valid && exp_q.size() == 0, "R9 no stale pend", irq_valid, 0);

    // R2: channel 1 disabled, then enabled while high
    wr(16'hBE32);
    chan_set[1]++;
    step(10);
    check(!irq_valid, "R2 disabled channel", irq_valid, 0);
    exp_q = '{chv(1)};
    wr(16'hFE32);
    drain();

    // R10: hold while unacknowledged, despite late high-level event
    auto_ack = 1'b0;
    chan_set[5]++;
    step(3);
    check(irq_valid && irq_vector == chv(5), "R10 presented", irq_vector, chv(5));
    ill_op = 1; step(); ill_op = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      check(irq_valid && irq_vector == chv(5), "R10 held", irq_vector, chv(5));
    end
    exp_q = '{chv(5), 7'h06};
    auto_ack = 1'b1;
    drain();

    // R12: reset request flushes pending events, level source returns
    wr(16'hFE36);
    auto_ack = 1'b0;
    chan_set[4]++;
    step(3);
    check(irq_valid && irq_vector == chv(4), "R12 pre", irq_vector, chv(4));
    swi_exec = 1; pa_edge_n = 0; step(); swi_exec = 0; pa_edge_n = 1;
    step();
    rst_req = 1; step();
    check(!irq_valid && reset_out, "R12 override", {irq_valid, reset_out}, 1);
    rst_req = 0; step();
    check(!reset_out, "R12 reset_out drops", reset_out, 0);
    exp_q = '{chv(4)};
    auto_ack = 1'b1;
    drain();
    check(!irq_valid, "R12 no flushed events", irq_valid, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule